// File: doc/BRIEF.md
# Write Completion Poller

This block runs on the host side of a paged nonvolatile memory and decides when the memory has finished an internal programming cycle. A one-cycle start request carries the last address written, the byte written to it and a mode select. The block then issues a string of read cycles through a plain request/data interface. It judges each returned byte with one of two in-band status encodings, and ends with a one-cycle done or error pulse.

In polarity mode (`mode_i = 0`), the memory returns the inverse of the written bit 7 while it is still programming, so the first read whose bit 7 matches the written bit 7 marks completion. In toggle mode (`mode_i = 1`), bit 6 flips on every read while the memory is busy, and its starting and final values cannot be predicted. Completion is therefore the first read whose bit 6 equals the bit 6 of the read just before it. In both modes the block then makes one extra read and accepts completion only if the whole byte matches the written data.

Read pacing has two parameters. The strobe is `STROBE_CYC` cycles long. The recovery gap with the strobe low is `GAP_CYC` cycles, which sets the minimum output-enable-high time between reads. `MAX_READS` bounds the number of status reads. The FSM states are `S_IDLE`, `S_POLL_RD` (status read strobe), `S_GAP` (recovery between reads) and `S_CONF_RD` (confirming read). Its transitions are:
- IDLE→POLL_RD on start.
- POLL_RD→GAP at strobe end.
- POLL_RD→IDLE on timeout.
- GAP→POLL_RD when no completion has been seen.
- GAP→CONF_RD once completion has been seen.
- CONF_RD→IDLE at strobe end.

Top module: `wr_done_poller`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o` and `err_o` are all low.
- R2: `start_i` is taken only in IDLE, where it captures address, data and mode. A start while busy is ignored and does not change the address read or the outcome.
- R3: Every read holds `rd_req_o` high for exactly `STROBE_CYC` cycles, with `rd_addr_o` equal to the captured address. Consecutive reads of one poll are separated by exactly `GAP_CYC` low cycles.
- R4: In polarity mode (mode 0), polling completes on the first read whose bit 7 equals bit 7 of the written byte.
- R5: In toggle mode (mode 1), the first read only sets a reference. Polling completes on the first later read whose bit 6 equals bit 6 of the previous read.
- R6: After completion, exactly one confirming read is made. If all 8 bits equal the written byte, `done_o` pulses.
- R7: If the confirming read differs in any bit, `err_o` pulses instead of `done_o`.
- R8: If `MAX_READS` status reads pass without completion, `err_o` pulses and no confirming read is made.
- R9: `done_o` and `err_o` are single-cycle pulses and never high together. Each appears in the cycle after the last strobe cycle of the deciding read, and `busy_o` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a poll (one cycle) |
| mode_i | input | 1 | 0 = bit-7 polarity, 1 = bit-6 toggle |
| addr_i | input | AW | Last written address |
| data_i | input | 8 | Last written byte |
| rd_req_o | output | 1 | Read strobe |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | 8 | Data returned by the memory, sampled on the last strobe cycle |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Completion confirmed (pulse) |
| err_o | output | 1 | Timeout or confirm mismatch (pulse) |

## Verification
A behavioural memory model in the bench returns a chosen number of busy reads, then the stored byte. Busy reads carry an inverted bit 7 and a bit 6 that flips on each read. The randomized runs vary mode, busy length and the starting toggle phase. The toggle phase decides whether toggle mode finishes one read or two after the memory goes idle, which tells a correct previous-read comparison from an off-by-one. Directed cases cover:
- zero busy reads in both modes;
- a busy count that lands exactly on the read limit against one read past it, which separates the completion check from the timeout;
- a corrupted final byte, which exercises the confirming read;
- a start issued mid-poll with different address, data and mode.

// File: rtl/wcp_pkg.sv
package wcp_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_POLL_RD = 2'd1,
        S_GAP     = 2'd2,
        S_CONF_RD = 2'd3
    } wcp_state_e;

    typedef enum logic {
        M_POLARITY = 1'b0,
        M_TOGGLE   = 1'b1
    } wcp_mode_e;

    localparam int POL_BIT = 7;
    localparam int TOG_BIT = 6;
endpackage

// File: rtl/wcp_phase_timer.sv
module wcp_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // a loaded count only ever decreases until the next load
    AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/wcp_status_eval.sv
module wcp_status_eval
    import wcp_pkg::*;
(
    input  wcp_mode_e   mode_i,
    input  logic [7:0]  wdata_i,
    input  logic [7:0]  rdata_i,
    input  logic        ref_valid_i,
    input  logic        ref_tog_i,
    output logic        complete_o,
    output logic        match_o
);
    always_comb begin
        unique case (mode_i)
            M_POLARITY: complete_o = (rdata_i[POL_BIT] == wdata_i[POL_BIT]);
            M_TOGGLE:   complete_o = ref_valid_i && (rdata_i[TOG_BIT] == ref_tog_i);
            default:    complete_o = 1'b0;
        endcase
        match_o = (rdata_i == wdata_i);
    end
endmodule

// File: rtl/wr_done_poller.sv
module wr_done_poller
    import wcp_pkg::*;
#(
    parameter int AW         = 15,
    parameter int STROBE_CYC = 3,
    parameter int GAP_CYC    = 8,
    parameter int MAX_READS  = 65535
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int TMAX = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(MAX_READS + 1);
    localparam logic [TW-1:0] STROBE_LD = TW'(STROBE_CYC - 1);
    localparam logic [TW-1:0] GAP_LD    = TW'(GAP_CYC - 1);
    localparam logic [RW-1:0] LAST_IDX  = RW'(MAX_READS - 1);

    wcp_state_e    state_q, state_d;
    wcp_mode_e     mode_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    wdata_q;
    logic [RW-1:0] reads_q;
    logic          ref_valid_q, ref_tog_q, conf_q;
    logic          done_q, err_q;

    logic          tmr_zero, tmr_load;
    logic [TW-1:0] tmr_val;
    logic          complete, match, last_read;

    wcp_phase_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    wcp_status_eval u_eval (
        .mode_i      (mode_q),
        .wdata_i     (wdata_q),
        .rdata_i     (rd_data_i),
        .ref_valid_i (ref_valid_q),
        .ref_tog_i   (ref_tog_q),
        .complete_o  (complete),
        .match_o     (match)
    );

    assign last_read = (reads_q == LAST_IDX);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_POLL_RD;
            S_POLL_RD: if (tmr_zero) begin
                           if (!complete && last_read) state_d = S_IDLE;
                           else                        state_d = S_GAP;
                       end
            S_GAP:     if (tmr_zero) state_d = conf_q ? S_CONF_RD : S_POLL_RD;
            S_CONF_RD: if (tmr_zero) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
        tmr_load = (state_d != state_q);
        tmr_val  = (state_d == S_GAP) ? GAP_LD : STROBE_LD;
    end

    // state and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            mode_q      <= M_POLARITY;
            addr_q      <= '0;
            wdata_q     <= '0;
            reads_q     <= '0;
            ref_valid_q <= 1'b0;
            ref_tog_q   <= 1'b0;
            conf_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                mode_q      <= wcp_mode_e'(mode_i);
                addr_q      <= addr_i;
                wdata_q     <= data_i;
                reads_q     <= '0;
                ref_valid_q <= 1'b0;
                conf_q      <= 1'b0;
            end else if (state_q == S_POLL_RD && tmr_zero) begin
                reads_q     <= reads_q + 1'b1;
                ref_tog_q   <= rd_data_i[TOG_BIT];
                ref_valid_q <= 1'b1;
                if (complete) conf_q <= 1'b1;
            end
        end
    end

    // result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == S_CONF_RD) && tmr_zero && match;
            err_q  <= ((state_q == S_CONF_RD) && tmr_zero && !match) ||
                      ((state_q == S_POLL_RD) && tmr_zero && !complete && last_read);
        end
    end

    assign rd_req_o  = (state_q == S_POLL_RD) || (state_q == S_CONF_RD);
    assign rd_addr_o = addr_q;
    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R9
    AST_DONE_AFTER_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state_q == S_CONF_RD)); // R6
    AST_BUSY_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(rd_addr_o) && $stable(wdata_q))); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        reads_q <= RW'(MAX_READS)); // R8
endmodule

// File: tb/wr_done_poller_bench.sv
module wr_done_poller_bench;
    localparam int AW   = 15;
    localparam int STB  = 3;
    localparam int GAP  = 4;
    localparam int MAXR = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0]    rd_data_i;
    logic          busy_o, done_o, err_o;

    wr_done_poller #(.AW(AW), .STROBE_CYC(STB), .GAP_CYC(GAP), .MAX_READS(MAXR)) u_wr_done_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .addr_i(addr_i), .data_i(data_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // memory model state
    int            m_busy = 0;
    logic          m_tog = 1'b0;
    logic [7:0]    m_store = '0;
    logic [7:0]    m_wr = '0;
    logic [7:0]    m_noise = '0;
    logic [AW-1:0] exp_addr = '0;

    always_comb begin
        if (m_busy > 0) rd_data_i = {~m_wr[7], m_tog, m_noise[5:0]};
        else            rd_data_i = m_store;
    end

    // read monitor
    int   reads = 0, hi_cnt = 0, lo_cnt = 0;
    int   strobe_err = 0, gap_err = 0, addr_err = 0;
    logic prev_req = 1'b0;

    always @(negedge clk) begin
        if (rd_req_o) begin
            if (!prev_req) begin
                if (reads > 0 && lo_cnt != GAP) gap_err++;
                reads++;
                hi_cnt = 1;
            end else hi_cnt++;
            if (rd_addr_o != exp_addr) addr_err++;
        end else begin
            if (prev_req) begin
                if (hi_cnt != STB) strobe_err++;
                if (m_busy > 0) begin
                    m_busy--;
                    m_tog = ~m_tog;
                end
                lo_cnt = 1;
            end else lo_cnt++;
        end
        prev_req = rd_req_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int exp_polls(input logic m, input int b, input logic [7:0] w, input logic t0);
        logic last;
        if (m == 1'b0) return b + 1;
        if (b == 0) return 2;
        last = t0 ^ logic'((b - 1) & 1);
        return (last == w[6]) ? b + 1 : b + 2;
    endfunction

    task automatic run_case(input logic m, input logic [AW-1:0] a, input logic [7:0] w,
                            input int b, input logic t0, input logic bad, input logic poke);
        int polls, exp_reads, waitc;
        bit exp_done, got_done, got_err;
        string tag;
        @(negedge clk);
        m_busy = b; m_tog = t0; m_wr = w; m_noise = 8'($urandom);
        m_store = bad ? (w ^ 8'h01) : w;
        exp_addr = a;
        reads = 0; strobe_err = 0; gap_err = 0; addr_err = 0;
        start_i = 1'b1; mode_i = m; addr_i = a; data_i = w;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            chk(busy_o == 1'b1, "R2 busy before mid-poll start", int'(busy_o), 1);
            start_i = 1'b1; mode_i = ~m; addr_i = ~a; data_i = ~w;
            @(negedge clk);
            start_i = 1'b0;
        end
        waitc = 0;
        while (!done_o && !err_o && waitc < 5000) begin
            @(negedge clk);
            waitc++;
        end
        got_done = done_o; got_err = err_o;
        chk(busy_o == 1'b0, "R9 busy low with result pulse", int'(busy_o), 0);
        @(negedge clk);
        chk(!done_o && !err_o, "R9 single-cycle result", int'({done_o, err_o}), 0);
        polls = exp_polls(m, b, w, t0);
        if (polls > MAXR) begin
            exp_done = 1'b0; exp_reads = MAXR; tag = "R8 timeout";
        end else begin
            exp_done = !bad; exp_reads = polls + 1;
            tag = bad ? "R7 confirm mismatch" : (m ? "R5 toggle done" : "R4 polarity done");
        end
        chk(got_done == exp_done && got_err == !exp_done, tag, int'({got_done, got_err}),
            int'({exp_done, !exp_done}));
        chk(reads == exp_reads, m ? "R5/R6 read count" : "R4/R6 read count", reads, exp_reads);
        chk(strobe_err == 0 && gap_err == 0, "R3 strobe/gap width", strobe_err + gap_err, 0);
        chk(addr_err == 0, poke ? "R2 address kept" : "R3 read address", addr_err, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(rd_req_o == 1'b0, "R1 rd_req after reset", int'(rd_req_o), 0);
        chk(done_o == 1'b0 && err_o == 1'b0, "R1 pulses after reset", int'({done_o, err_o}), 0);

        // directed corners
        run_case(1'b0, 15'h1234, 8'hA5, 0, 1'b0, 1'b0, 1'b0);  // R4 immediate
        run_case(1'b1, 15'h0042, 8'h3C, 0, 1'b0, 1'b0, 1'b0);  // R5 two reads minimum
        run_case(1'b1, 15'h7FC0, 8'h40, 3, 1'b1, 1'b0, 1'b0);  // R5 last busy bit6 matches
        run_case(1'b1, 15'h7FC0, 8'h40, 3, 1'b0, 1'b0, 1'b0);  // R5 needs extra read
        run_case(1'b0, 15'h2AAA, 8'h80, MAXR - 1, 1'b0, 1'b0, 1'b0); // R8 boundary: done
        run_case(1'b0, 15'h5555, 8'h80, MAXR, 1'b0, 1'b0, 1'b0);     // R8 timeout
        run_case(1'b1, 15'h0100, 8'h00, MAXR, 1'b0, 1'b0, 1'b0);     // R8 toggle timeout
        run_case(1'b0, 15'h0203, 8'h7E, 2, 1'b0, 1'b1, 1'b0);  // R7
        run_case(1'b1, 15'h0203, 8'hC3, 2, 1'b1, 1'b1, 1'b0);  // R7 toggle
        run_case(1'b0, 15'h0ABC, 8'h11, 4, 1'b0, 1'b0, 1'b1);  // R2 ignored start

        // constrained random
        for (int i = 0; i < 20; i++) begin
            run_case(logic'($urandom_range(0, 1)), AW'($urandom), 8'($urandom),
                     int'($urandom_range(0, 13)), logic'($urandom_range(0, 1)),
                     logic'($urandom_range(0, 7) == 0), 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule